// File: doc/BRIEF.md
# Dual-Mode Lane-to-Word Deserializer

The block collects serial bits from up to four lanes and assembles them into one 27-bit parallel word per pixel period. A bit strobe replaces the bit-rate clock multiplier. On each strobe one bit is taken from every lane. A frame marker, taken from the clock lane, shows which strobe carries the first bit of a period. In narrow mode all four lanes carry 7 bits per period. In wide mode only the two even lanes are used, and each carries 14 bits per period. In both modes the period holds 28 bit slots, and one of them is a reserved slot that is discarded.

Each finished word is registered and flagged with a one-cycle valid pulse. A reverse select flips the whole bus end for end. The block also produces a pixel-rate output clock from the slot count. An edge select decides whether the word is stable around the rising or the falling edge of that clock. The block must see a marker before it produces anything. A change of mode drops alignment until the next marker.

Top module: `lane_deser`

## Requirements
- R1: After reset, `word_out` is 0, `word_vld` is 0 and `pclk_out` is 0.
- R2: In narrow mode (`wide_mode`=0), slot s (0 = the marked strobe, 6 = the last) of lane k carries word bit 7k+6−s. Lane 3 at slot 0 carries the reserved slot.
- R3: In wide mode (`wide_mode`=1), lane 0 at slot s carries bit 13−s. Lane 2 carries the reserved slot at slot 0 and bit 27−s at slots 1..13. Lanes 1 and 3 have no effect on the word.
- R4: The value carried in the reserved slot never appears on `word_out`.
- R5: `word_vld` stays 0 until one complete period has been collected after a marker. It then pulses for one cycle, in the cycle after the strobe of the last slot, together with the new `word_out`.
- R6: When `rev_sel` is 1 at the last-slot strobe, `word_out[i]` carries word bit 26−i. When it is 0, the word is not reversed.
- R7: After the strobe of slot s in a period of N slots (N = 7 or 14): with `edge_sel`=1, `pclk_out` is 1 exactly when s ≥ N/2 (4 of 7 high, 7 of 14). With `edge_sel`=0, it is 1 exactly when s < N/2 (3 of 7 high, 7 of 14). So the word changes half a pixel clock away from the chosen edge.
- R8: If `wide_mode` differs from the mode captured at the last marker, the block loses alignment on that edge. `pclk_out` goes to 0 and no valid is produced until a new marker is seen and a full period has been collected.
- R9: Without further markers, the slot count wraps at 7 or 14. Every following complete period produces a valid word.
- R10: A marker in the middle of a period restarts the count at slot 0. The partial period is discarded and produces no valid.
- R11: In cycles where `bit_en` is 0, no slot is consumed and `word_out` and `pclk_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| bit_en | input | 1 | Bit strobe: one bit per lane is taken |
| frame_mark | input | 1 | Marks the strobe carrying slot 0 |
| lane_in | input | 4 | Sampled lane bits, lane k on bit k |
| wide_mode | input | 1 | 0: four lanes × 7, 1: two lanes × 14 |
| rev_sel | input | 1 | Reverse the output bus |
| edge_sel | input | 1 | 1: word centred on rising edge, 0: falling |
| word_out | output | 27 | Assembled word |
| word_vld | output | 1 | One-cycle pulse when a new word is loaded |
| pclk_out | output | 1 | Pixel-rate output clock |

## Verification
The directed frames use distinct non-symmetric words, with the reserved slot driven to 1 and junk on the idle lanes. A wrong lane, slot or reversal mapping therefore shows up as a word mismatch, and a leak of the reserved slot or an idle lane shows up as a set bit. Gapped strobes show whether idle cycles are wrongly counted as slots. Mid-period markers and mid-period mode flips show whether a partial frame is ever emitted. Per-slot checks of the output clock in both modes and both edge settings separate the 4/3 split from the 7/7 split. A long random phase mixes all of these and compares the outputs with a behavioural model on every clock.

// File: rtl/deser_pkg.sv
package deser_pkg;
   typedef enum logic {
      MODE_NARROW = 1'b0,
      MODE_WIDE   = 1'b1
   } lane_mode_e;
endpackage

// File: rtl/lane_shifter.sv
module lane_shifter #(
   parameter int LANES   = 4,
   parameter int SHORT_N = 7
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       shift_en,
   input  logic [LANES-1:0]           bit_in,
   output logic [LANES*2*SHORT_N-1:0] taps
);
   localparam int LONG_N = 2 * SHORT_N;

   // even lanes may carry a long period, odd lanes only ever a short one
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      if ((k % 2) == 0) begin : g_long
         logic [LONG_N-2:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        sr <= '0;
            else if (shift_en) sr <= {sr[LONG_N-3:0], bit_in[k]};
         end
         assign taps[k*LONG_N +: LONG_N] = {sr, bit_in[k]};
      end else begin : g_short
         logic [SHORT_N-2:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        sr <= '0;
            else if (shift_en) sr <= {sr[SHORT_N-3:0], bit_in[k]};
         end
         assign taps[k*LONG_N +: LONG_N] = {{SHORT_N{1'b0}}, sr, bit_in[k]};
      end
   end
endmodule

// File: rtl/word_mapper.sv
module word_mapper #(
   parameter int LANES   = 4,
   parameter int SHORT_N = 7,
   parameter int WORD_W  = 27
) (
   input  logic                       wide,
   input  logic                       rev,
   input  logic [LANES*2*SHORT_N-1:0] taps,
   output logic [WORD_W-1:0]          word
);
   localparam int LONG_N = 2 * SHORT_N;
   localparam int FLAT_W = LANES * SHORT_N;

   logic [FLAT_W-1:0] flat_n;
   logic [FLAT_W-1:0] flat_w;
   logic [WORD_W-1:0] sel_word;
   logic [WORD_W-1:0] rev_word;
   logic [(LANES/2)*SHORT_N-1:0] unused_odd_hi;
   logic unused_rsv;

   for (genvar k = 0; k < LANES; k++) begin : g_narrow
      assign flat_n[k*SHORT_N +: SHORT_N] = taps[k*LONG_N +: SHORT_N];
      if ((k % 2) == 1) begin : g_odd
         assign unused_odd_hi[(k/2)*SHORT_N +: SHORT_N] = taps[k*LONG_N+SHORT_N +: SHORT_N];
      end
   end

   for (genvar j = 0; j < LANES/2; j++) begin : g_wide
      assign flat_w[j*LONG_N +: LONG_N] = taps[2*j*LONG_N +: LONG_N];
   end

   // the top slot of the flattened period is the reserved one
   assign unused_rsv = flat_n[FLAT_W-1] ^ flat_w[FLAT_W-1] ^ (^unused_odd_hi);
   assign sel_word   = wide ? flat_w[WORD_W-1:0] : flat_n[WORD_W-1:0];

   for (genvar i = 0; i < WORD_W; i++) begin : g_rev
      assign rev_word[i] = sel_word[WORD_W-1-i];
   end

   assign word = rev ? rev_word : sel_word;
endmodule

// File: rtl/frame_counter.sv
module frame_counter
   import deser_pkg::*;
#(
   parameter int SHORT_N = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic frame_mark,
   input  logic wide_mode,
   input  logic edge_sel,
   output logic emit,
   output logic wide_eff,
   output logic pclk
);
   localparam int LONG_N = 2 * SHORT_N;
   localparam int SW     = $clog2(LONG_N);

   lane_mode_e    mode_q, mode_in, mode_eff;
   logic          lock_q;
   logic [SW-1:0] nxt_q, slot_in, last_eff, half_eff;
   logic          mark, mode_drop, live;

   assign mark      = bit_en & frame_mark;
   assign mode_in   = lane_mode_e'(wide_mode);
   assign mode_drop = lock_q && (mode_in != mode_q) && !mark;
   assign mode_eff  = mark ? mode_in : mode_q;
   assign live      = mark || (lock_q && !mode_drop);
   assign last_eff  = (mode_eff == MODE_WIDE) ? SW'(LONG_N - 1) : SW'(SHORT_N - 1);
   assign half_eff  = (mode_eff == MODE_WIDE) ? SW'(LONG_N / 2) : SW'(SHORT_N / 2);
   assign slot_in   = mark ? '0 : nxt_q;
   assign emit      = bit_en && live && (slot_in == last_eff);
   assign wide_eff  = (mode_eff == MODE_WIDE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
         mode_q <= MODE_NARROW;
         nxt_q  <= '0;
         pclk   <= 1'b0;
      end else begin
         if (mark) begin
            lock_q <= 1'b1;
            mode_q <= mode_in;
         end else if (mode_drop) begin
            lock_q <= 1'b0;
         end
         if (mode_drop) begin
            nxt_q <= '0;
            pclk  <= 1'b0;
         end else if (bit_en && live) begin
            nxt_q <= (slot_in == last_eff) ? '0 : slot_in + SW'(1);
            pclk  <= edge_sel ? (slot_in >= half_eff) : (slot_in < half_eff);
         end
      end
   end

   // R9
   narrow_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && mode_q == MODE_NARROW) |-> (nxt_q < SW'(SHORT_N)));
   // R9
   wide_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |-> (nxt_q < SW'(LONG_N)));
   // R8
   drop_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_drop |=> (!lock_q && !pclk));
   // R11
   pclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pclk) |-> $past(bit_en || mode_drop));
endmodule

// File: rtl/lane_deser.sv
module lane_deser #(
   parameter int LANES   = 4,
   parameter int SHORT_N = 7,
   localparam int WORD_W = LANES * SHORT_N - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              frame_mark,
   input  logic [LANES-1:0]  lane_in,
   input  logic              wide_mode,
   input  logic              rev_sel,
   input  logic              edge_sel,
   output logic [WORD_W-1:0] word_out,
   output logic              word_vld,
   output logic              pclk_out
);
   localparam int LONG_N = 2 * SHORT_N;

   if (LANES < 2 || (LANES % 2) != 0) begin : g_bad_lanes
      $error("lane_deser: LANES must be even and at least 2");
   end
   if (SHORT_N < 3) begin : g_bad_short
      $error("lane_deser: SHORT_N must be at least 3");
   end

   logic [LANES*LONG_N-1:0] taps;
   logic [WORD_W-1:0]       mapped;
   logic                    emit, wide_eff;

   lane_shifter #(.LANES(LANES), .SHORT_N(SHORT_N)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (bit_en),
      .bit_in   (lane_in),
      .taps     (taps)
   );

   frame_counter #(.SHORT_N(SHORT_N)) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_en     (bit_en),
      .frame_mark (frame_mark),
      .wide_mode  (wide_mode),
      .edge_sel   (edge_sel),
      .emit       (emit),
      .wide_eff   (wide_eff),
      .pclk       (pclk_out)
   );

   word_mapper #(.LANES(LANES), .SHORT_N(SHORT_N), .WORD_W(WORD_W)) u_map (
      .wide (wide_eff),
      .rev  (rev_sel),
      .taps (taps),
      .word (mapped)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_out <= '0;
         word_vld <= 1'b0;
      end else begin
         word_vld <= emit;
         if (emit) word_out <= mapped;
      end
   end

   // R5
   vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |=> !word_vld);
   // R11
   vld_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |-> $past(bit_en));
   // R11
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !word_vld |-> $stable(word_out));
endmodule

// File: tb/sim_lane_deser.sv
`timescale 1ns/1ps
module sim_lane_deser;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_en = 1'b0, frame_mark = 1'b0;
   logic [3:0]  lane_in = '0;
   logic        wide_mode = 1'b0, rev_sel = 1'b0, edge_sel = 1'b1;
   logic [26:0] word_out;
   logic        word_vld, pclk_out;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference model state
   bit          m_lock, m_mode, m_pclk, m_vld;
   int          m_next;
   logic [26:0] m_acc, m_word;

   always #5 clk = ~clk;

   lane_deser u0 (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_mark(frame_mark),
      .lane_in(lane_in), .wide_mode(wide_mode), .rev_sel(rev_sel),
      .edge_sel(edge_sel), .word_out(word_out), .word_vld(word_vld),
      .pclk_out(pclk_out)
   );

   function automatic logic [26:0] flip(input logic [26:0] w);
      logic [26:0] r;
      for (int i = 0; i < 27; i++) r[i] = w[26-i];
      return r;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_lock = 0; m_mode = 0; m_pclk = 0; m_vld = 0; m_next = 0;
      m_acc = '0; m_word = '0;
   endtask

   task automatic model_edge(input bit be, input bit fm, input logic [3:0] ln,
                             input bit wd, input bit rv, input bit ed);
      bit mark, drop;
      int slot, n, idx;
      mark = be && fm;
      drop = m_lock && (wd != m_mode) && !mark;
      m_vld = 0;
      if (drop) begin
         m_lock = 0; m_next = 0; m_pclk = 0;
      end else if (be && (mark || m_lock)) begin
         if (mark) begin m_lock = 1; m_mode = wd; slot = 0; end
         else slot = m_next;
         n = m_mode ? 14 : 7;
         for (int k = 0; k < 4; k++) begin
            if (!m_mode) begin
               idx = 7*k + 6 - slot;
               if (idx < 27) m_acc[idx] = ln[k];
            end else if (k == 0) begin
               m_acc[13-slot] = ln[k];
            end else if (k == 2 && slot > 0) begin
               m_acc[27-slot] = ln[k];
            end
         end
         m_pclk = ed ? (slot >= n/2) : (slot < n/2);
         if (slot == n-1) begin
            m_vld = 1; m_word = rv ? flip(m_acc) : m_acc; m_next = 0;
         end else begin
            m_next = slot + 1;
         end
      end
   endtask

   // one clock: drive at negedge, compare just after the posedge
   task automatic step(input bit be, input bit fm, input logic [3:0] ln);
      @(negedge clk);
      bit_en = be; frame_mark = fm; lane_in = ln;
      @(posedge clk);
      #1;
      model_edge(be, fm, ln, wide_mode, rev_sel, edge_sel);
      check(word_out == m_word, "R2/R3 word vs model", 32'(word_out), 32'(m_word));
      check(word_vld == m_vld, "R5 valid vs model", 32'(word_vld), 32'(m_vld));
      check(pclk_out == m_pclk, "R7 pclk vs model", 32'(pclk_out), 32'(m_pclk));
   endtask

   function automatic logic [3:0] lanes_for(input logic [26:0] d, input bit wd, input int s, input bit rsv);
      logic [3:0] l;
      l = 4'($urandom);
      if (!wd) begin
         for (int k = 0; k < 4; k++) l[k] = (7*k + 6 - s == 27) ? rsv : d[7*k + 6 - s];
      end else begin
         l[0] = d[13-s];
         l[2] = (s == 0) ? rsv : d[27-s];
      end
      return l;
   endfunction

   // full period; optional idle gaps; per-slot clock check (R7)
   task automatic send_frame(input logic [26:0] d, input bit with_mark, input int gap);
      int n;
      bit exp_clk;
      n = wide_mode ? 14 : 7;
      for (int s = 0; s < n; s++) begin
         for (int g = 0; g < gap; g++) begin
            step(0, 0, 4'($urandom));
            check(word_vld == 0, "R11 idle no valid", 32'(word_vld), 0);
         end
         step(1, with_mark && s == 0, lanes_for(d, wide_mode, s, 1'b1));
         exp_clk = edge_sel ? (s >= n/2) : (s < n/2);
         check(pclk_out == exp_clk, "R7 pclk slot", 32'(pclk_out), 32'(exp_clk));
      end
   endtask

   task automatic expect_word(input logic [26:0] exp, input string tag);
      check(word_vld == 1, {tag, " valid"}, 32'(word_vld), 1);
      check(word_out == exp, {tag, " word"}, 32'(word_out), 32'(exp));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=hung expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int vcount;
      model_reset();
      repeat (3) @(posedge clk);
      #1;
      // R1
      check(word_out == 0, "R1 reset word", 32'(word_out), 0);
      check(word_vld == 0, "R1 reset valid", 32'(word_vld), 0);
      check(pclk_out == 0, "R1 reset pclk", 32'(pclk_out), 0);
      @(negedge clk); rst_n = 1'b1;

      // R5: no valid before any marker
      vcount = 0;
      for (int i = 0; i < 25; i++) begin step(1, 0, 4'($urandom)); vcount += word_vld; end
      check(vcount == 0, "R5 no valid before marker", 32'(vcount), 0);

      // R2 / R4 narrow frame, reserved driven 1
      send_frame(27'h5A3C96F, 1, 0);
      expect_word(27'h5A3C96F, "R2 narrow");
      send_frame(27'h0000000, 0, 0);
      expect_word(27'h0000000, "R4 reserved dropped");
      // R9 wrap without marker
      send_frame(27'h1234567, 0, 0);
      expect_word(27'h1234567, "R9 wrap");
      // R6 reversal
      rev_sel = 1;
      send_frame(27'h0F0F0A1, 0, 0);
      expect_word(flip(27'h0F0F0A1), "R6 reversed");
      rev_sel = 0;
      // R11 gapped strobes
      edge_sel = 0;
      send_frame(27'h3ACE123, 0, 2);
      expect_word(27'h3ACE123, "R11 gapped");
      step(0, 0, 4'hF);
      check(word_out == 27'h3ACE123, "R11 hold word", 32'(word_out), 32'h3ACE123);

      // R8 mode change drops alignment
      wide_mode = 1;
      step(0, 0, 4'h0);
      check(pclk_out == 0, "R8 pclk low after drop", 32'(pclk_out), 0);
      vcount = 0;
      for (int i = 0; i < 30; i++) begin step(1, 0, 4'($urandom)); vcount += word_vld; end
      check(vcount == 0, "R8 no valid while unaligned", 32'(vcount), 0);

      // R3 wide frames, junk on lanes 1 and 3
      send_frame(27'h6DB1C25, 1, 0);
      expect_word(27'h6DB1C25, "R3 wide");
      edge_sel = 1;
      send_frame(27'h0000000, 0, 0);
      expect_word(27'h0000000, "R3 idle lanes ignored R4");

      // R8 mid-period mode flip
      for (int s = 0; s < 5; s++) step(1, s == 0, 4'($urandom));
      wide_mode = 0;
      vcount = 0;
      for (int i = 0; i < 20; i++) begin step(1, 0, 4'($urandom)); vcount += word_vld; end
      check(vcount == 0, "R8 mid-period flip", 32'(vcount), 0);

      // R10 marker mid-period
      send_frame(27'h2468ACE, 1, 0);
      expect_word(27'h2468ACE, "R10 realign base");
      for (int s = 0; s < 3; s++) step(1, 0, 4'($urandom));
      vcount = 0;
      for (int s = 0; s < 6; s++) begin
         step(1, s == 0, lanes_for(27'h13579BD, 0, s, 1'b1));
         vcount += word_vld;
      end
      check(vcount == 0, "R10 partial dropped", 32'(vcount), 0);
      step(1, 0, lanes_for(27'h13579BD, 0, 6, 1'b1));
      expect_word(27'h13579BD, "R10 realigned");

      // mixed random phase against the model
      for (int i = 0; i < 4000; i++) begin
         if ($urandom % 250 == 0) wide_mode = ~wide_mode;
         if ($urandom % 60 == 0) rev_sel = ~rev_sel;
         if ($urandom % 80 == 0) edge_sel = ~edge_sel;
         begin
            bit be;
            be = ($urandom % 4) != 0;
            step(be, be && ($urandom % 30 == 0), 4'($urandom));
         end
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule